// File: doc/BRIEF.md
# Multi-Service Line Data Readback Bank

This block takes decoded line-data captures from four data services and exposes one of them to a host through a shared bank of byte registers. The four services are a program guide service that runs at single or double rate, a video programming signal service, a program delivery control service and a universal time code service. Each capture arrives as a one-cycle valid strobe. The strobe carries a service code, a byte count, a double-rate line flag and a 13-byte payload. The host chooses one service with a 2-bit selector. Only captures from that service reach the bank, and the newest accepted capture replaces whatever the bank held before.

The host also sees a status register. It holds a data-available flag and a rate-type bit. The rate-type bit tells the host whether the last program guide capture carried two or four valid bytes. Detection of the rate is switched on by an enable bit in the configuration register. The same status address also accepts a write-only, self-clearing clear command, which re-initialises the bank.

The host port is a plain synchronous bus with an 8-bit address, a write enable, write data and registered read data. Reads have no side effects. The external reset is asynchronous and active low, and it is released synchronously inside the block.

Top module: `svc_readback`

## Requirements
- R1: The configuration register at 0xA0 holds the service selector in bits [1:0], with 00 for the program guide, 01 for the video programming signal, 10 for program delivery control and 11 for the time code. It holds the rate auto-detect enable in bit 2. All other bits read 0, and the register resets to 0x00.
- R2: A capture whose service code differs from the selector leaves all bank bytes, the available flag and the type bit unchanged.
- R3: The bank has 13 bytes at addresses 0x84 through 0x90. After an accepted capture, address 0x84+i returns payload byte i. Each accepted capture overwrites the previous contents.
- R4: Bank bytes whose index is at or above the capture's byte count read 0. A byte count above 13 is treated as 13.
- R5: Writing a 1 to bit 7 of the status register at 0xA1 zeroes every bank byte, the available flag and the type bit. Bit 7 always reads back 0. A clear wins over a capture in the same cycle.
- R6: Status bit 0 is the available flag. It is 0 after reset and becomes 1 after an accepted capture.
- R7: Writing a new selector value clears the available flag, and any capture in that same cycle is dropped. Rewriting the current selector value has no effect.
- R8: Status bit 1 is set by an accepted program guide capture only when three things hold: auto-detect is enabled, the capture's double-rate flag is set, and its byte count is at least 4. Any other accepted capture sets bit 1 to 0, and the bit resets to 0.
- R9: Read data appears on the clock edge after the address is presented. Unmapped addresses read 0x00. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cap_vld | input | 1 | One-cycle capture strobe |
| cap_svc | input | 2 | Service code of the capture |
| cap_cnt | input | 4 | Number of valid payload bytes |
| cap_dbl | input | 1 | Line was decoded in double-rate mode |
| cap_data | input | 104 | Payload, byte i in bits [8i+7:8i] |

## Verification
A capture or a host write changes the bank, the flags and the selector at the clock edge where it is sampled. A read presented at the next falling edge returns that state after one further rising edge, because read data passes through one register. The bench therefore applies every stimulus for exactly one rising edge. It then reads each address with the address driven at a falling edge and the data sampled at the following falling edge, so that each comparison lands on the cycle where the registered value is due. Same-cycle collisions are driven as a single cycle, so the priority between them is tested: a clear against a capture, and a selector change against a capture.

// File: rtl/svc_rb_pkg.sv
package svc_rb_pkg;
  typedef enum logic [1:0] {
    SVC_GUIDE   = 2'b00,
    SVC_PROGSIG = 2'b01,
    SVC_DELIV   = 2'b10,
    SVC_TIME    = 2'b11
  } svc_e;

  localparam int BYTE_W = 8;
  localparam int CFG_AUTO_BIT = 2;
  localparam int STAT_AVAIL_BIT = 0;
  localparam int STAT_TYPE_BIT = 1;
  localparam int STAT_CLR_BIT = 7;
endpackage

// File: rtl/svc_rb_regs.sv
module svc_rb_regs
  import svc_rb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CFG_ADDR = 'hA0,
  parameter int STAT_ADDR = 'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [1:0]        sel_q,
  output logic              auto_q,
  output logic              clr_pulse,
  output logic              sel_chg
);
  logic       cfg_hit;
  logic       stat_hit;
  logic [1:0] sel_d;
  logic       auto_d;
  logic       cfg_en;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[6:3]};

  always_comb begin
    cfg_hit   = we && (addr == ADDR_W'(CFG_ADDR));
    stat_hit  = we && (addr == ADDR_W'(STAT_ADDR));
    cfg_en    = cfg_hit;
    sel_d     = wdata[1:0];
    auto_d    = wdata[CFG_AUTO_BIT];
    sel_chg   = cfg_hit && (wdata[1:0] != sel_q);
    clr_pulse = stat_hit && wdata[STAT_CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SVC_GUIDE;
      auto_q <= 1'b0;
    end else if (cfg_en) begin
      sel_q  <= sel_d;
      auto_q <= auto_d;
    end
  end
endmodule

// File: rtl/svc_rb_capture.sv
module svc_rb_capture
  import svc_rb_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int DBL_BYTES = 4,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic [1:0]                    sel,
  input  logic                          auto_en,
  input  logic                          clr,
  input  logic                          sel_chg,
  input  logic                          cap_vld,
  input  logic [1:0]                    cap_svc,
  input  logic [CNT_W-1:0]              cap_cnt,
  input  logic                          cap_dbl,
  input  logic [NBYTES-1:0][BYTE_W-1:0] cap_data,
  output logic                          load,
  output logic [NBYTES-1:0][BYTE_W-1:0] load_data,
  output logic                          load_type
);
  logic [CNT_W-1:0] cnt_sat;

  always_comb begin
    cnt_sat   = (cap_cnt > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : cap_cnt;
    load      = cap_vld && (cap_svc == sel) && !clr && !sel_chg;
    load_type = (cap_svc == SVC_GUIDE) && auto_en && cap_dbl &&
                (cnt_sat >= CNT_W'(DBL_BYTES));
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_mask
    always_comb begin
      if (CNT_W'(i) < cnt_sat) load_data[i] = cap_data[i];
      else                     load_data[i] = '0;
    end
  end
endmodule

// File: rtl/svc_rb_bank.sv
module svc_rb_bank
  import svc_rb_pkg::*;
#(
  parameter int NBYTES = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          sel_chg,
  input  logic                          load,
  input  logic [NBYTES-1:0][BYTE_W-1:0] load_data,
  input  logic                          load_type,
  output logic [NBYTES-1:0][BYTE_W-1:0] bank_q,
  output logic                          avail_q,
  output logic                          rtype_q
);
  logic avail_d;
  logic rtype_d;
  logic flag_en;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_d;
    logic              byte_en;

    always_comb begin
      byte_en = clr || load;
      byte_d  = clr ? '0 : load_data[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q[i] <= '0;
      else if (byte_en) bank_q[i] <= byte_d;
    end
  end

  always_comb begin
    flag_en = clr || sel_chg || load;
    avail_d = avail_q;
    rtype_d = rtype_q;
    if (clr) begin
      avail_d = 1'b0;
      rtype_d = 1'b0;
    end else if (sel_chg) begin
      avail_d = 1'b0;
    end else if (load) begin
      avail_d = 1'b1;
      rtype_d = load_type;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      rtype_q <= 1'b0;
    end else if (flag_en) begin
      avail_q <= avail_d;
      rtype_q <= rtype_d;
    end
  end
endmodule

// File: rtl/svc_readback.sv
module svc_readback
  import svc_rb_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int ADDR_W = 8,
  parameter int BANK_BASE = 'h84,
  parameter int CFG_ADDR = 'hA0,
  parameter int STAT_ADDR = 'hA1,
  parameter int DBL_BYTES = 4,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_we,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [BYTE_W-1:0]        host_wdata,
  output logic [BYTE_W-1:0]        host_rdata,
  input  logic                     cap_vld,
  input  logic [1:0]               cap_svc,
  input  logic [CNT_W-1:0]         cap_cnt,
  input  logic                     cap_dbl,
  input  logic [NBYTES*BYTE_W-1:0] cap_data
);
  logic                          rst_meta_n;
  logic                          rst_q_n;
  logic [1:0]                    sel_q;
  logic                          auto_q;
  logic                          clr_pulse;
  logic                          sel_chg;
  logic                          load;
  logic [NBYTES-1:0][BYTE_W-1:0] load_data;
  logic                          load_type;
  logic [NBYTES-1:0][BYTE_W-1:0] bank_q;
  logic                          avail_q;
  logic                          rtype_q;
  logic [BYTE_W-1:0]             rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  svc_rb_regs #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_q_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .sel_q(sel_q), .auto_q(auto_q),
    .clr_pulse(clr_pulse), .sel_chg(sel_chg)
  );

  svc_rb_capture #(
    .NBYTES(NBYTES), .DBL_BYTES(DBL_BYTES)
  ) cap_i (
    .sel(sel_q), .auto_en(auto_q), .clr(clr_pulse), .sel_chg(sel_chg),
    .cap_vld(cap_vld), .cap_svc(cap_svc), .cap_cnt(cap_cnt),
    .cap_dbl(cap_dbl), .cap_data(cap_data), .load(load),
    .load_data(load_data), .load_type(load_type)
  );

  svc_rb_bank #(
    .NBYTES(NBYTES)
  ) bank_i (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_pulse), .sel_chg(sel_chg),
    .load(load), .load_data(load_data), .load_type(load_type),
    .bank_q(bank_q), .avail_q(avail_q), .rtype_q(rtype_q)
  );

  always_comb begin
    rdata_d = '0;
    if (host_addr == ADDR_W'(CFG_ADDR)) begin
      rdata_d[1:0]          = sel_q;
      rdata_d[CFG_AUTO_BIT] = auto_q;
    end else if (host_addr == ADDR_W'(STAT_ADDR)) begin
      rdata_d[STAT_AVAIL_BIT] = avail_q;
      rdata_d[STAT_TYPE_BIT]  = rtype_q;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (host_addr == ADDR_W'(BANK_BASE + i)) rdata_d = bank_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) host_rdata <= '0;
    else          host_rdata <= rdata_d;
  end
endmodule

// File: rtl/svc_rb_chk.sv
module svc_rb_chk
  import svc_rb_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int ADDR_W = 8,
  parameter int CFG_ADDR = 'hA0,
  parameter int STAT_ADDR = 'hA1
) (
  input logic                          clk,
  input logic                          rst_q_n,
  input logic                          host_we,
  input logic [ADDR_W-1:0]             host_addr,
  input logic [BYTE_W-1:0]             host_wdata,
  input logic                          cap_vld,
  input logic [1:0]                    cap_svc,
  input logic [1:0]                    sel_q,
  input logic                          auto_q,
  input logic [NBYTES-1:0][BYTE_W-1:0] bank_q,
  input logic                          avail_q,
  input logic                          rtype_q
);
  logic clr_w;
  logic cfg_w;

  assign clr_w = host_we && (host_addr == ADDR_W'(STAT_ADDR)) && host_wdata[STAT_CLR_BIT];
  assign cfg_w = host_we && (host_addr == ADDR_W'(CFG_ADDR));

  // R5
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    clr_w |=> (!avail_q && !rtype_q && (bank_q == '0)));

  // R2
  foreign_ignore_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cap_vld && (cap_svc != sel_q) && !host_we) |=>
      ($stable(bank_q) && $stable(avail_q) && $stable(rtype_q)));

  // R6
  accept_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cap_vld && (cap_svc == sel_q) && !host_we) |=> avail_q);

  // R7
  selchg_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_w && (host_wdata[1:0] != sel_q)) |=> (!avail_q && $stable(bank_q)));

  // R8
  type_auto_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rtype_q) |-> ($past(auto_q) && ($past(sel_q) == SVC_GUIDE)));

  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!host_we && !cap_vld) |=>
      ($stable(bank_q) && $stable(avail_q) && $stable(rtype_q) && $stable(sel_q)));
endmodule

bind svc_readback svc_rb_chk #(
  .NBYTES(NBYTES), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .cap_vld(cap_vld), .cap_svc(cap_svc),
  .sel_q(sel_q), .auto_q(auto_q), .bank_q(bank_q), .avail_q(avail_q),
  .rtype_q(rtype_q)
);

// File: tb/svc_readback_tb.sv
module svc_readback_tb_top;
  localparam int NB = 13;
  localparam logic [7:0] CFG = 8'hA0;
  localparam logic [7:0] STAT = 8'hA1;
  localparam logic [7:0] BASE = 8'h84;

  logic            clk;
  logic            rst_n;
  logic            host_we;
  logic [7:0]      host_addr;
  logic [7:0]      host_wdata;
  logic [7:0]      host_rdata;
  logic            cap_vld;
  logic [1:0]      cap_svc;
  logic [3:0]      cap_cnt;
  logic            cap_dbl;
  logic [NB*8-1:0] cap_data;

  int total = 0;
  int bad = 0;
  logic [7:0] m_bank [NB];
  bit         m_av;
  bit         m_ty;
  logic [1:0] m_sel;
  bit         m_auto;

  svc_readback dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cap_vld(cap_vld),
    .cap_svc(cap_svc), .cap_cnt(cap_cnt), .cap_dbl(cap_dbl), .cap_data(cap_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37 + 5);
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // One cycle with an optional write and an optional capture, model updated from the requirements
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     input bit cv, input logic [1:0] cs, input logic [3:0] cn,
                     input bit cd, input logic [7:0] seed);
    bit clr, chg, acc;
    int lim;
    @(negedge clk);
    host_we = wr; host_addr = a; host_wdata = d;
    cap_vld = cv; cap_svc = cs; cap_cnt = cn; cap_dbl = cd;
    for (int i = 0; i < NB; i++) cap_data[i*8 +: 8] = pay(seed, i);
    @(posedge clk);
    clr = wr && (a == STAT) && d[7];
    chg = wr && (a == CFG) && (d[1:0] != m_sel);
    acc = cv && (cs == m_sel) && !clr && !chg;
    lim = (cn > 13) ? 13 : int'(cn);
    if (clr) begin
      for (int i = 0; i < NB; i++) m_bank[i] = 8'h00;
      m_av = 0; m_ty = 0;
    end else if (chg) begin
      m_av = 0;
    end else if (acc) begin
      for (int i = 0; i < NB; i++) m_bank[i] = (i < lim) ? pay(seed, i) : 8'h00;
      m_av = 1;
      m_ty = (cs == 2'b00) && m_auto && cd && (lim >= 4);
    end
    if (wr && a == CFG) begin m_sel = d[1:0]; m_auto = d[2]; end
    @(negedge clk);
    host_we = 0; cap_vld = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    host_we = 0; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic check_all(input string ctx);
    logic [7:0] v;
    rd(CFG, v);  chk(v, {5'd0, m_auto, m_sel}, {"R1 cfg ", ctx});
    rd(STAT, v); chk(v, {6'd0, m_ty, m_av}, {"R5/R6/R8 status ", ctx});
    for (int i = 0; i < NB; i++) begin
      rd(BASE + 8'(i), v);
      chk(v, m_bank[i], $sformatf("R3/R4 byte %0d %s", i, ctx));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit [3:0] cnts [6] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd13, 4'd15};
    host_we = 0; host_addr = 0; host_wdata = 0;
    cap_vld = 0; cap_svc = 0; cap_cnt = 0; cap_dbl = 0; cap_data = '0;
    for (int i = 0; i < NB; i++) m_bank[i] = 0;
    m_av = 0; m_ty = 0; m_sel = 0; m_auto = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R6 reset state
    check_all("reset");
    // R9 unmapped read
    rd(8'h50, v); chk(v, 8'h00, "R9 unmapped");

    // R2 R3 R4 R8 sweep over selector, auto, service, count, rate flag
    for (int au = 0; au < 2; au++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1, CFG, {5'd0, 1'(au), 2'(s)}, 0, 0, 0, 0, 0);
        check_all($sformatf("R7 after sel=%0d", s));
        for (int c = 0; c < 4; c++) begin
          for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 0, 1, 2'(c), cnts[k], 1'(k[0]), 8'(s*64 + c*16 + k));
            check_all($sformatf("R2 sel=%0d svc=%0d cnt=%0d", s, c, cnts[k]));
          end
        end
      end
    end

    // R5 clear against a same-cycle capture on the selected service
    cyc(1, CFG, 8'h04, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 4'd4, 1, 8'h3C);
    check_all("R8 dbl guide before clear");
    cyc(1, STAT, 8'h80, 1, 0, 4'd13, 1, 8'h77);
    check_all("R5 clear beats capture");

    // R7 selector change drops the same-cycle capture
    cyc(0, 0, 0, 1, 0, 4'd13, 0, 8'h11);
    cyc(1, CFG, 8'h01, 1, 0, 4'd13, 0, 8'h22);
    check_all("R7 change with capture");
    // R7 rewriting the same value keeps the flag and accepts a capture
    cyc(0, 0, 0, 1, 1, 4'd6, 0, 8'h44);
    cyc(1, CFG, 8'h01, 1, 1, 4'd3, 0, 8'h55);
    check_all("R7 same value rewrite");
    // R5 clear bit on non-set write is harmless
    cyc(1, STAT, 8'h00, 0, 0, 0, 0, 0);
    check_all("R5 clear bit zero");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule